// File: doc/BRIEF.md
# Message-Signalled Interrupt File

This block is the interrupt file of one hart. Devices and other harts raise an interrupt by writing an identity number to a memory-mapped doorbell word. Software injects inter-processor interrupts the same way. The write sets that identity's pending bit. The block holds a pending bit and an enable bit for every implemented identity. It also holds a delivery switch and a priority threshold. All of this state is reached through an indirect port: the caller presents a select code and an operation, either read, write, bit-set or bit-clear. Each operation returns the register's previous contents one cycle later.

Every cycle the block picks the lowest-numbered identity that is pending, enabled and below the threshold, and publishes it in a top-interrupt word. The hart's external-interrupt request line follows that word. The hart claims an interrupt with a one-cycle claim strobe. The strobe returns the live top-interrupt word and clears that identity's pending bit atomically. Software repeats the claim until the returned word is zero. The number of identities, `NUM_IDS`, is a parameter of the form 64k−1 with a value from 63 to 2047.

Top module: `imf_file`

## Requirements
- R1: After a synchronous reset every pending bit, every enable bit, the delivery switch and the threshold are 0, and `topi` and `ext_irq` are 0.
- R2: A write to doorbell offset 0x000 whose 32-bit value V satisfies 1 ≤ V ≤ NUM_IDS sets pending bit V. Values 0 and V > NUM_IDS are ignored, and writes to any offset other than 0x000 and 0x004 are ignored.
- R3: A write to doorbell offset 0x004 is byte-reversed before decoding (byte 3 of the bus word becomes bits 7:0) and then obeys R2.
- R4: Select 0x70 holds the delivery switch in bit 0. Select 0x72 holds the 11-bit threshold in bits 10:0. Select 0x80+n is pending word n and 0xC0+n is enable word n, for n < (NUM_IDS+1)/32, and bit i of word n is identity 32n+i. Every other select code reads as 0 and ignores writes.
- R5: `reg_op` encodes 0 = read, 1 = write, 2 = bit-set (OR), 3 = bit-clear (AND-NOT). `reg_rdata` shows the selected register's value before the operation, in the cycle after `reg_en`.
- R6: Pending bit 0 and enable bit 0 always read as 0, so identity 0 is never reported.
- R7: The top identity is the lowest identity whose pending and enable bits are both 1 and which passes the threshold. It is 0 when no identity qualifies or the delivery switch is 0.
- R8: A threshold of 0 masks nothing. A threshold T ≠ 0 lets only identities below T qualify, so T = 1 masks all.
- R9: `topi` carries the top identity in bits 26:16 and again in bits 10:0, with all other bits 0. `ext_irq` is 1 exactly when `topi` is nonzero. Both are registered and reflect state one clock after it changes.
- R10: A `claim` strobe returns the live top word on `claim_data` in the next cycle and clears only that identity's pending bit. A doorbell write of the same identity in the same cycle wins, so the bit stays set. A claim that finds top 0 clears nothing. `claim_data` is 0 in cycles after no claim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_we | input | 1 | Doorbell write strobe |
| msg_addr | input | 12 | Doorbell page offset |
| msg_data | input | 32 | Doorbell write value |
| reg_en | input | 1 | Indirect access strobe |
| reg_op | input | 2 | Indirect operation code |
| reg_sel | input | 8 | Indirect select code |
| reg_wdata | input | 32 | Indirect operand |
| reg_rdata | output | 32 | Previous register value, one cycle later |
| claim | input | 1 | Atomic claim strobe |
| claim_data | output | 32 | Top word returned by a claim |
| topi | output | 32 | Registered top-interrupt word |
| ext_irq | output | 1 | External-interrupt request to the hart |

## Verification
The hardest situations to reach are those where several updates to one pending bit land on the same edge. Examples are a claim coinciding with a fresh doorbell for the identity being claimed, and back-to-back claims where the second must see the state left by the first. The bench drives the claim strobe on consecutive cycles and overlaps a doorbell with a claim in one cycle. It also sweeps every identity through both byte orders and every threshold value up to one past the identity range, so each priority and masking decision is observed at the ports.

// File: rtl/imf_pkg.sv
package imf_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } reg_op_e;

  localparam int WORD_W      = 32;
  localparam int TOP_FIELD_W = 11;
  localparam int WIDX_W      = 6;

  localparam logic [7:0]  SEL_DELIVER = 8'h70;
  localparam logic [7:0]  SEL_THRESH  = 8'h72;
  localparam logic [1:0]  SEL_PEND_HI = 2'b10;
  localparam logic [1:0]  SEL_ENAB_HI = 2'b11;
  localparam logic [11:0] OFS_SET_LE  = 12'h000;
  localparam logic [11:0] OFS_SET_BE  = 12'h004;

  function automatic logic [31:0] swap_bytes(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  function automatic logic [31:0] apply_op(input reg_op_e op, input logic [31:0] cur,
                                           input logic [31:0] d);
    case (op)
      OP_WRITE: return d;
      OP_SET:   return cur | d;
      OP_CLEAR: return cur & ~d;
      default:  return cur;
    endcase
  endfunction
endpackage

// File: rtl/imf_msg_decode.sv
module imf_msg_decode
  import imf_pkg::*;
#(
  parameter int NUM_IDS = 63,
  parameter int IDW     = 6
) (
  input  logic           we,
  input  logic [11:0]    addr,
  input  logic [31:0]    wdata,
  output logic           set_vld,
  output logic [IDW-1:0] set_id
);
  logic [31:0] val;
  logic        hit;

  always_comb begin
    hit     = (addr == OFS_SET_LE) || (addr == OFS_SET_BE);
    val     = (addr == OFS_SET_BE) ? swap_bytes(wdata) : wdata;
    set_vld = we && hit && (val != 32'd0) && (val <= 32'(NUM_IDS));
    set_id  = val[IDW-1:0];
  end
endmodule

// File: rtl/imf_bit_array.sv
module imf_bit_array
  import imf_pkg::*;
#(
  parameter int NREG = 2,
  parameter int IDW  = 6,
  localparam int NBITS = NREG * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [WIDX_W-1:0] wr_word,
  input  reg_op_e           wr_op,
  input  logic [31:0]       wr_data,
  input  logic              clr_vld,
  input  logic [IDW-1:0]    clr_id,
  input  logic              set_vld,
  input  logic [IDW-1:0]    set_id,
  output logic [NBITS-1:0]  bits
);
  for (genvar w = 0; w < NREG; w++) begin : g_word
    logic [31:0] q;
    logic [31:0] nxt;

    always_comb begin
      nxt = q;
      if (wr_en && (wr_word == WIDX_W'(w))) nxt = apply_op(wr_op, q, wr_data);
      for (int b = 0; b < WORD_W; b++) begin
        if (clr_vld && (clr_id == IDW'(w * WORD_W + b))) nxt[b] = 1'b0;
        if (set_vld && (set_id == IDW'(w * WORD_W + b))) nxt[b] = 1'b1;
      end
      if (w == 0) nxt[0] = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= nxt;
    end

    assign bits[w*WORD_W +: WORD_W] = q;
  end
endmodule

// File: rtl/imf_prio_pick.sv
module imf_prio_pick
  import imf_pkg::*;
#(
  parameter int NUM_IDS = 63,
  parameter int IDW     = 6,
  localparam int NBITS = NUM_IDS + 1
) (
  input  logic [NBITS-1:0]       pend,
  input  logic [NBITS-1:0]       enab,
  input  logic                   deliver,
  input  logic [TOP_FIELD_W-1:0] thresh,
  output logic [IDW-1:0]         top_id
);
  always_comb begin
    top_id = '0;
    for (int i = NUM_IDS; i >= 1; i--) begin
      if (pend[i] && enab[i] &&
          ((thresh == '0) || (TOP_FIELD_W'(i) < thresh)))
        top_id = IDW'(i);
    end
    if (!deliver) top_id = '0;
  end
endmodule

// File: rtl/imf_file.sv
module imf_file
  import imf_pkg::*;
#(
  parameter int NUM_IDS = 63
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        msg_we,
  input  logic [11:0] msg_addr,
  input  logic [31:0] msg_data,
  input  logic        reg_en,
  input  logic [1:0]  reg_op,
  input  logic [7:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        claim,
  output logic [31:0] claim_data,
  output logic [31:0] topi,
  output logic        ext_irq
);
  localparam int NBITS = NUM_IDS + 1;
  localparam int NREG  = NBITS / WORD_W;
  localparam int IDW   = $clog2(NBITS);

  reg_op_e                op;
  logic                   sel_pend, sel_enab, word_ok;
  logic                   set_vld;
  logic [IDW-1:0]         set_id;
  logic [NBITS-1:0]       pend_bits, enab_bits;
  logic                   dlv_q;
  logic [TOP_FIELD_W-1:0] thr_q;
  logic [IDW-1:0]         top_id;
  logic [31:0]            top_word;
  logic [31:0]            rd_val;
  logic [31:0]            dlv_nxt, thr_nxt;
  logic [31:0]            topi_q, claim_q, rdata_q;
  logic                   irq_q;

  assign op       = reg_op_e'(reg_op);
  assign sel_pend = reg_sel[7:6] == SEL_PEND_HI;
  assign sel_enab = reg_sel[7:6] == SEL_ENAB_HI;
  assign word_ok  = {1'b0, reg_sel[5:0]} < 7'(NREG);

  imf_msg_decode #(.NUM_IDS(NUM_IDS), .IDW(IDW)) u_dec (
    .we      (msg_we),
    .addr    (msg_addr),
    .wdata   (msg_data),
    .set_vld (set_vld),
    .set_id  (set_id)
  );

  imf_bit_array #(.NREG(NREG), .IDW(IDW)) u_pend (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_en && sel_pend && word_ok),
    .wr_word (reg_sel[5:0]),
    .wr_op   (op),
    .wr_data (reg_wdata),
    .clr_vld (claim && (top_id != '0)),
    .clr_id  (top_id),
    .set_vld (set_vld),
    .set_id  (set_id),
    .bits    (pend_bits)
  );

  imf_bit_array #(.NREG(NREG), .IDW(IDW)) u_enab (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (reg_en && sel_enab && word_ok),
    .wr_word (reg_sel[5:0]),
    .wr_op   (op),
    .wr_data (reg_wdata),
    .clr_vld (1'b0),
    .clr_id  ('0),
    .set_vld (1'b0),
    .set_id  ('0),
    .bits    (enab_bits)
  );

  imf_prio_pick #(.NUM_IDS(NUM_IDS), .IDW(IDW)) u_pick (
    .pend    (pend_bits),
    .enab    (enab_bits),
    .deliver (dlv_q),
    .thresh  (thr_q),
    .top_id  (top_id)
  );

  assign top_word = {5'b0, TOP_FIELD_W'(top_id), 5'b0, TOP_FIELD_W'(top_id)};

  // previous value of the selected register
  always_comb begin
    rd_val = '0;
    if (reg_sel == SEL_DELIVER) rd_val = {31'b0, dlv_q};
    else if (reg_sel == SEL_THRESH) rd_val = {21'b0, thr_q};
    else begin
      for (int w = 0; w < NREG; w++) begin
        if (reg_sel[5:0] == WIDX_W'(w)) begin
          if (sel_pend) rd_val = pend_bits[w*WORD_W +: WORD_W];
          if (sel_enab) rd_val = enab_bits[w*WORD_W +: WORD_W];
        end
      end
    end
  end

  always_comb begin
    dlv_nxt = apply_op(op, {31'b0, dlv_q}, reg_wdata);
    thr_nxt = apply_op(op, {21'b0, thr_q}, reg_wdata);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dlv_q   <= 1'b0;
      thr_q   <= '0;
      topi_q  <= '0;
      irq_q   <= 1'b0;
      claim_q <= '0;
      rdata_q <= '0;
    end else begin
      if (reg_en && reg_sel == SEL_DELIVER) dlv_q <= dlv_nxt[0];
      if (reg_en && reg_sel == SEL_THRESH)  thr_q <= thr_nxt[TOP_FIELD_W-1:0];
      if (reg_en) rdata_q <= rd_val;
      topi_q  <= top_word;
      irq_q   <= top_id != '0;
      claim_q <= claim ? top_word : '0;
    end
  end

  assign reg_rdata  = rdata_q;
  assign claim_data = claim_q;
  assign topi       = topi_q;
  assign ext_irq    = irq_q;
endmodule

// File: rtl/imf_file_chk.sv
module imf_file_chk #(
  parameter int NUM_IDS = 63,
  localparam int NBITS = NUM_IDS + 1,
  localparam int IDW   = $clog2(NBITS)
) (
  input logic             clk,
  input logic             rst,
  input logic             msg_we,
  input logic [11:0]      msg_addr,
  input logic [31:0]      msg_data,
  input logic [31:0]      topi,
  input logic             ext_irq,
  input logic             dlv_q,
  input logic [10:0]      thr_q,
  input logic [NBITS-1:0] pend_bits
);
  AST_IRQ_TRACKS_TOP: assert property (@(posedge clk) disable iff (rst)
    ext_irq == (topi != 32'd0)); // R9

  AST_TOP_FIELDS_MIRROR: assert property (@(posedge clk) disable iff (rst)
    (topi[26:16] == topi[10:0]) && (topi[31:27] == 5'd0) && (topi[15:11] == 5'd0)); // R9

  AST_DELIVERY_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(dlv_q) |-> topi == 32'd0); // R7

  AST_THRESH_ONE_MASKS: assert property (@(posedge clk) disable iff (rst)
    ($past(thr_q) == 11'd1) |-> topi == 32'd0); // R8

  AST_DOORBELL_SETS: assert property (@(posedge clk) disable iff (rst)
    (msg_we && msg_addr == 12'h000 && msg_data != 32'd0 && msg_data <= 32'(NUM_IDS))
      |=> pend_bits[$past(msg_data[IDW-1:0])]); // R2
endmodule

bind imf_file imf_file_chk #(.NUM_IDS(NUM_IDS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .msg_we    (msg_we),
  .msg_addr  (msg_addr),
  .msg_data  (msg_data),
  .topi      (topi),
  .ext_irq   (ext_irq),
  .dlv_q     (dlv_q),
  .thr_q     (thr_q),
  .pend_bits (pend_bits)
);

// File: tb/tb_imf_file.sv
module tb_imf_file;
  localparam int NUM_IDS = 63;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        msg_we = 1'b0;
  logic [11:0] msg_addr = '0;
  logic [31:0] msg_data = '0;
  logic        reg_en = 1'b0;
  logic [1:0]  reg_op = '0;
  logic [7:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        claim = 1'b0;
  logic [31:0] claim_data;
  logic [31:0] topi;
  logic        ext_irq;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  imf_file #(.NUM_IDS(NUM_IDS)) dut (
    .clk(clk), .rst(rst),
    .msg_we(msg_we), .msg_addr(msg_addr), .msg_data(msg_data),
    .reg_en(reg_en), .reg_op(reg_op), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .claim(claim), .claim_data(claim_data),
    .topi(topi), .ext_irq(ext_irq)
  );

  function automatic logic [31:0] enc(input int id);
    return (32'(id) << 16) | 32'(id);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic [1:0] op, input logic [7:0] sel,
                     input logic [31:0] d, output logic [31:0] r);
    reg_en = 1'b1; reg_op = op; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0;
    r = reg_rdata;
  endtask

  task automatic ring(input logic [11:0] a, input logic [31:0] d);
    msg_we = 1'b1; msg_addr = a; msg_data = d;
    @(negedge clk);
    msg_we = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic [31:0] c1, c2, c3;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk(topi == 0, "R1 topi", topi, 0);
    chk(ext_irq == 0, "R1 irq", {31'b0, ext_irq}, 0);
    foreach (r[i]) ; // no-op
    acc(2'd0, 8'h70, 0, r); chk(r == 0, "R1 delivery", r, 0);
    acc(2'd0, 8'h72, 0, r); chk(r == 0, "R1 thresh", r, 0);
    acc(2'd0, 8'h80, 0, r); chk(r == 0, "R1 pend0", r, 0);
    acc(2'd0, 8'hC1, 0, r); chk(r == 0, "R1 enab1", r, 0);

    // enable all; R6 bit 0 reads zero
    acc(2'd1, 8'hC0, 32'hFFFF_FFFF, r);
    acc(2'd1, 8'hC1, 32'hFFFF_FFFF, r);
    acc(2'd0, 8'hC0, 0, r); chk(r == 32'hFFFF_FFFE, "R6 enab bit0", r, 32'hFFFF_FFFE);
    acc(2'd1, 8'h80, 32'h1, r);
    acc(2'd0, 8'h80, 0, r); chk(r == 0, "R6 pend bit0", r, 0);

    // R7 delivery off keeps top at zero
    ring(12'h000, 32'd5); settle();
    acc(2'd0, 8'h80, 0, r); chk(r == 32'h20, "R2 set id5", r, 32'h20);
    settle();
    chk(topi == 0, "R7 delivery off", topi, 0);
    acc(2'd1, 8'h70, 32'h1, r); settle();
    chk(topi == enc(5), "R7 top id5", topi, enc(5));
    chk(ext_irq == 1, "R9 irq high", {31'b0, ext_irq}, 1);
    acc(2'd0, 8'h70, 0, r); chk(r == 1, "R4 delivery readback", r, 1);

    // R2 ignored doorbells
    ring(12'h000, 32'd0);
    ring(12'h000, 32'd64);
    ring(12'h000, 32'd1000);
    ring(12'h008, 32'd3);
    ring(12'h004, 32'd3);
    acc(2'd0, 8'h80, 0, r); chk(r == 32'h20, "R2 ignored word0", r, 32'h20);
    acc(2'd0, 8'h81, 0, r); chk(r == 0, "R2 ignored word1", r, 0);

    // R3 byte-reversed doorbell
    ring(12'h004, 32'h2800_0000);
    acc(2'd0, 8'h81, 0, r); chk(r == 32'h100, "R3 id40", r, 32'h100);

    // R2 R3 R7 R9 sweep over every identity
    for (int id = 1; id <= NUM_IDS; id++) begin
      logic [31:0] d;
      acc(2'd1, 8'h80, 0, r);
      acc(2'd1, 8'h81, 0, r);
      d = 32'(id);
      if (id % 2 == 1) ring(12'h000, d);
      else ring(12'h004, {d[7:0], d[15:8], d[23:16], d[31:24]});
      settle();
      chk(topi == enc(id), "R7 sweep top", topi, enc(id));
      acc(2'd0, 8'h80 + 8'(id / 32), 0, r);
      chk(r == (32'h1 << (id % 32)), "R2 sweep pend", r, 32'h1 << (id % 32));
    end

    // R8 threshold sweep with only id 40 pending
    acc(2'd1, 8'h80, 0, r);
    acc(2'd1, 8'h81, 32'h100, r);
    for (int t = 0; t <= 64; t++) begin
      logic [31:0] e;
      acc(2'd1, 8'h72, 32'(t), r);
      settle();
      e = (t == 0 || 40 < t) ? enc(40) : 0;
      chk(topi == e, "R8 thresh sweep", topi, e);
    end
    acc(2'd1, 8'h72, 0, r);

    // R5 set / clear ops on enable with pending 5 and 40
    ring(12'h000, 32'd5);
    acc(2'd3, 8'hC0, 32'h20, r); chk(r == 32'hFFFF_FFFE, "R5 clear returns old", r, 32'hFFFF_FFFE);
    settle();
    chk(topi == enc(40), "R5 clear enable", topi, enc(40));
    acc(2'd0, 8'hC0, 0, r); chk(r == 32'hFFFF_FFDE, "R5 clear result", r, 32'hFFFF_FFDE);
    acc(2'd2, 8'hC0, 32'h20, r); settle();
    chk(topi == enc(5), "R5 set enable", topi, enc(5));

    // R4 unimplemented selects
    acc(2'd1, 8'h82, 32'hFFFF_FFFF, r);
    acc(2'd0, 8'h82, 0, r); chk(r == 0, "R4 word2 absent", r, 0);
    acc(2'd1, 8'h71, 32'hFFFF_FFFF, r);
    acc(2'd0, 8'h71, 0, r); chk(r == 0, "R4 code71 absent", r, 0);
    acc(2'd1, 8'h72, 32'hFFFF_F805, r);
    acc(2'd0, 8'h72, 0, r); chk(r == 32'h5, "R4 thresh width", r, 32'h5);
    acc(2'd1, 8'h72, 0, r);
    settle();
    chk(topi == enc(5), "R4 top unchanged", topi, enc(5));

    // R10 back-to-back claims
    claim = 1'b1;
    @(negedge clk); c1 = claim_data;
    @(negedge clk); c2 = claim_data;
    @(negedge clk); c3 = claim_data;
    claim = 1'b0;
    chk(c1 == enc(5), "R10 first claim", c1, enc(5));
    chk(c2 == enc(40), "R10 second claim", c2, enc(40));
    chk(c3 == 0, "R10 empty claim", c3, 0);
    settle();
    chk(claim_data == 0, "R10 idle data", claim_data, 0);
    chk(topi == 0, "R10 drained top", topi, 0);
    chk(ext_irq == 0, "R9 irq low", {31'b0, ext_irq}, 0);

    // R10 claim with same-cycle doorbell of the claimed id
    ring(12'h000, 32'd7); settle();
    claim = 1'b1; msg_we = 1'b1; msg_addr = 12'h000; msg_data = 32'd7;
    @(negedge clk);
    claim = 1'b0; msg_we = 1'b0;
    chk(claim_data == enc(7), "R10 race data", claim_data, enc(7));
    acc(2'd0, 8'h80, 0, r); chk(r == 32'h80, "R10 doorbell wins", r, 32'h80);
    claim = 1'b1; @(negedge clk); claim = 1'b0;
    acc(2'd0, 8'h80, 0, r); chk(r == 0, "R10 claim clears", r, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule